// File: doc/BRIEF.md
# Minutes-Seconds Stopwatch Core

This block keeps elapsed time as four BCD digits, minutes then seconds, in the form MM:SS. A control state machine responds to three single-cycle pulses: reset, start and stop. It decides whether the count advances. A free-running divider inside the block counts system clocks. Each time a whole second has passed while the watch is running, it raises a one-cycle enable. All registers run on the single system clock, and no derived clock is used.

Reset does not clear the time to zero. It loads a preset, 59:00 by default, and leaves the watch waiting for start. While the watch runs, the seconds and minutes count in mixed radix. Each units digit rolls over after 9 and each tens digit rolls over after 5. After 59:59 the time wraps to 00:00 and counting continues. The four digits and a running flag go to a separate display driver, which handles segment decoding and digit multiplexing.

Top module: `sw_mmss_top`

## Requirements
- R1: Four 4-bit outputs carry BCD digits: seconds units, seconds tens, minutes units and minutes tens. Packed as {min_tens, min_ones, sec_tens, sec_ones}, they read as hexadecimal MMSS.
- R2: A synchronous reset loads the preset (16'h5900 by default) into the digits, clears running_o and puts the controller in its idle state. Reset takes priority over start and stop.
- R3: When the watch is idle or stopped, a start pulse without stop raises running_o at the next clock edge.
- R4: While running_o is low, the digits do not change unless reset is applied.
- R5: If start and stop are both high in one cycle, stop wins. A running watch stops, and an idle or stopped watch stays where it is.
- R6: After start from idle, the first increment of the seconds units digit occurs exactly DIV clock edges after the edge that raised running_o, where DIV = CLK_HZ/TICK_HZ.
- R7: The seconds units digit counts 0 to 9. Its rollover advances the seconds tens digit, which counts 0 to 5.
- R8: A rollover of seconds tens advances minutes units (0 to 9). A rollover of minutes units advances minutes tens (0 to 5).
- R9: One second after 59:59 the time reads 00:00, and the watch keeps running.
- R10: Stop keeps the partial second. After a resume, the next increment comes when the remaining clocks of that second have run out.
- R11: running_o is high exactly while the watch is counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, loads the preset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| sec_ones_o | output | 4 | Seconds units digit, BCD |
| sec_tens_o | output | 4 | Seconds tens digit, BCD |
| min_ones_o | output | 4 | Minutes units digit, BCD |
| min_tens_o | output | 4 | Minutes tens digit, BCD |
| running_o | output | 1 | High while counting |

## Verification
A wrong controller state appears at running_o on the very next clock edge. A wrong phase in the divider first shows up at the next second boundary, when the seconds digit moves one or more clocks early or late. A carry-chain fault stays hidden until its digit rolls over. The bench therefore compares every output on every cycle against a cycle-accurate model and drives the count through each rollover, including the full-hour wrap.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        SW_IDLE    = 2'd0,
        SW_RUNNING = 2'd1,
        SW_STOPPED = 2'd2
    } sw_state_e;

    localparam int NUM_DIGITS = 4;
    localparam int DIGIT_W    = 4;

    // Digit order: 0 = seconds units, 1 = seconds tens, 2 = minutes units, 3 = minutes tens
    function automatic int digit_max(input int idx);
        return (idx % 2 == 0) ? 9 : 5;
    endfunction

endpackage

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
    parameter int DIV = 36_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_regs_t;

    tick_regs_t r_d, r_q;
    logic at_last;

    always_comb begin
        r_d     = r_q;
        at_last = (r_q.cnt == LAST);
        tick_o  = run_i && at_last;
        if (rst || clear_i) begin
            r_d.cnt = '0;
        end else if (run_i) begin
            r_d.cnt = at_last ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        r_q.cnt <= LAST);

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (r_q.cnt == '0));

    assert_hold_fraction_R10: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clear_i) |=> $stable(r_q.cnt));

endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
    import sw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic stop_i,
    output logic running_o,
    output logic idle_o
);
    typedef struct packed {
        sw_state_e st;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.st = SW_IDLE;
        end else begin
            unique case (r_q.st)
                SW_IDLE: begin
                    if (start_i && !stop_i) r_d.st = SW_RUNNING;
                end
                SW_RUNNING: begin
                    if (stop_i) r_d.st = SW_STOPPED;
                end
                SW_STOPPED: begin
                    if (start_i && !stop_i) r_d.st = SW_RUNNING;
                end
                default: r_d.st = SW_IDLE;
            endcase
        end
        running_o = (r_q.st == SW_RUNNING);
        idle_o    = (r_q.st == SW_IDLE);
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assert_reset_idle_R2: assert property (@(posedge clk)
        rst |=> (r_q.st == SW_IDLE));

    assert_start_runs_R3: assert property (@(posedge clk) disable iff (rst)
        (r_q.st != SW_RUNNING && start_i && !stop_i) |=> (r_q.st == SW_RUNNING));

    assert_stop_wins_R5: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (r_q.st != SW_RUNNING));

    assert_no_return_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (r_q.st != SW_IDLE) |=> (r_q.st != SW_IDLE));

endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit #(
    parameter int         MAX_VAL  = 9,
    parameter logic [3:0] INIT_VAL = 4'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       inc_i,
    output logic [3:0] val_o,
    output logic       carry_o
);
    localparam logic [3:0] TOP = 4'(MAX_VAL);

    typedef struct packed {
        logic [3:0] val;
    } dig_regs_t;

    dig_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        carry_o = inc_i && (r_q.val == TOP);
        if (rst) begin
            r_d.val = INIT_VAL;
        end else if (inc_i) begin
            r_d.val = (r_q.val == TOP) ? 4'd0 : r_q.val + 4'd1;
        end
        val_o = r_q.val;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assert_digit_range_R7: assert property (@(posedge clk) disable iff (rst)
        r_q.val <= TOP);

    assert_digit_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !inc_i |=> $stable(r_q.val));

endmodule

// File: rtl/sw_mmss_top.sv
module sw_mmss_top
    import sw_pkg::*;
#(
    parameter int          CLK_HZ  = 36_000_000,
    parameter int          TICK_HZ = 1,
    parameter logic [15:0] PRESET  = 16'h5900
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       stop_i,
    output logic [3:0] sec_ones_o,
    output logic [3:0] sec_tens_o,
    output logic [3:0] min_ones_o,
    output logic [3:0] min_tens_o,
    output logic       running_o
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic                  running;
    logic                  idle;
    logic                  tick;
    logic [NUM_DIGITS-1:0] inc;
    logic [NUM_DIGITS-1:0] carry;
    logic [DIGIT_W-1:0]    dig [NUM_DIGITS];
    logic                  hour_wrap;

    sw_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .running_o (running),
        .idle_o    (idle)
    );

    sw_tick_gen #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .clear_i (idle),
        .run_i   (running),
        .tick_o  (tick)
    );

    assign inc[0] = tick;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
        sw_bcd_digit #(
            .MAX_VAL  (digit_max(g)),
            .INIT_VAL (PRESET[4*g +: 4])
        ) u_dig (
            .clk     (clk),
            .rst     (rst),
            .inc_i   (inc[g]),
            .val_o   (dig[g]),
            .carry_o (carry[g])
        );
        if (g < NUM_DIGITS - 1) begin : g_chain
            assign inc[g+1] = carry[g];
        end
    end

    assign hour_wrap  = carry[NUM_DIGITS-1];
    assign sec_ones_o = dig[0];
    assign sec_tens_o = dig[1];
    assign min_ones_o = dig[2];
    assign min_tens_o = dig[3];
    assign running_o  = running;

    assert_preset_R2: assert property (@(posedge clk)
        rst |=> ({min_tens_o, min_ones_o, sec_tens_o, sec_ones_o} == PRESET) && !running_o);

    assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (rst)
        hour_wrap |=> ({min_tens_o, min_ones_o, sec_tens_o, sec_ones_o} == 16'h0000));

    assert_idle_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        !running_o |=> $stable({min_tens_o, min_ones_o, sec_tens_o, sec_ones_o}));

endmodule

// File: tb/sim_sw_mmss_top.sv
module sim_sw_mmss_top;
    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [3:0] sec_ones_o, sec_tens_o, min_ones_o, min_tens_o;
    logic       running_o;

    int    n_vec = 0;
    int    n_bad = 0;
    int    n_cyc = 0;
    string cur_req = "R2";

    // reference model state: 0 idle, 1 running, 2 stopped
    int          m_st = 0;
    int          m_cnt = 0;
    logic [15:0] m_time = 16'h5900;

    always #5 clk = ~clk;

    sw_mmss_top #(.CLK_HZ(DIV), .TICK_HZ(1), .PRESET(16'h5900)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .sec_ones_o(sec_ones_o), .sec_tens_o(sec_tens_o),
        .min_ones_o(min_ones_o), .min_tens_o(min_tens_o),
        .running_o(running_o)
    );

    function automatic logic [15:0] next_time(input logic [15:0] t);
        logic [3:0] so, st, mo, mt;
        {mt, mo, st, so} = t;
        if (so != 4'd9) so = so + 4'd1;
        else begin
            so = 4'd0;
            if (st != 4'd5) st = st + 4'd1;
            else begin
                st = 4'd0;
                if (mo != 4'd9) mo = mo + 4'd1;
                else begin
                    mo = 4'd0;
                    mt = (mt != 4'd5) ? mt + 4'd1 : 4'd0;
                end
            end
        end
        return {mt, mo, st, so};
    endfunction

    always @(posedge clk) begin
        n_cyc++;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_time = 16'h5900;
        end else begin
            if (m_st == 1) begin
                if (m_cnt == DIV - 1) begin
                    m_cnt = 0;
                    m_time = next_time(m_time);
                end else m_cnt++;
            end else if (m_st == 0) m_cnt = 0;
            if (stop_i) begin
                if (m_st == 1) m_st = 2;
            end else if (start_i && m_st != 1) m_st = 1;
        end
    end

    function automatic logic [15:0] dut_time();
        return {min_tens_o, min_ones_o, sec_tens_o, sec_ones_o};
    endfunction

    task automatic compare();
        n_vec++;
        if (dut_time() !== m_time || running_o !== (m_st == 1)) begin
            n_bad++;
            $display("FAIL %s: time=%h run=%b expected time=%h run=%b",
                     cur_req, dut_time(), running_o, m_time, (m_st == 1));
        end
    endtask

    task automatic check_time(input string req, input logic [15:0] exp, input logic exp_run);
        n_vec++;
        if (dut_time() !== exp || running_o !== exp_run) begin
            n_bad++;
            $display("FAIL %s: time=%h run=%b expected time=%h run=%b",
                     req, dut_time(), running_o, exp, exp_run);
        end
    endtask

    task automatic cyc(input logic r, input logic s, input logic p);
        rst = r; start_i = s; stop_i = p;
        @(negedge clk);
        compare();
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        int seed_use;
        seed_use = $urandom(32'd20240611);
        @(negedge clk);
        cur_req = "R2";
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        check_time("R2", 16'h5900, 1'b0);
        check_time("R1", {4'd5, 4'd9, 4'd0, 4'd0}, 1'b0);

        cur_req = "R4";
        idle_cycles(5);
        check_time("R4", 16'h5900, 1'b0);

        cur_req = "R5";
        cyc(1'b0, 1'b1, 1'b1);
        check_time("R5", 16'h5900, 1'b0);

        cur_req = "R3";
        cyc(1'b0, 1'b1, 1'b0);
        check_time("R3", 16'h5900, 1'b1);

        cur_req = "R6";
        idle_cycles(DIV - 1);
        check_time("R6", 16'h5900, 1'b1);
        idle_cycles(1);
        check_time("R6", 16'h5901, 1'b1);

        cur_req = "R7";
        idle_cycles(58 * DIV);
        check_time("R7", 16'h5959, 1'b1);

        cur_req = "R9";
        idle_cycles(DIV);
        check_time("R9", 16'h0000, 1'b1);

        cur_req = "R8";
        idle_cycles(600 * DIV);
        check_time("R8", 16'h1000, 1'b1);

        cur_req = "R10";
        idle_cycles(1);
        cyc(1'b0, 1'b1, 1'b1);
        check_time("R5", 16'h1000, 1'b0);
        idle_cycles(7);
        check_time("R4", 16'h1000, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        idle_cycles(DIV - 3);
        check_time("R10", 16'h1000, 1'b1);
        idle_cycles(1);
        check_time("R10", 16'h1001, 1'b1);

        cur_req = "R2";
        cyc(1'b1, 1'b1, 1'b0);
        check_time("R2", 16'h5900, 1'b0);

        cur_req = "R11";
        for (int i = 0; i < 20000; i++) begin
            logic r, s, p;
            r = ($urandom % 500) == 0;
            s = ($urandom % 15) == 0;
            p = ($urandom % 40) == 0;
            cyc(r, s, p);
        end

        cur_req = "R8";
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        idle_cycles(3600 * DIV);
        check_time("R9", 16'h5900, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait (n_cyc > 150000);
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", n_cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule